// File: doc/BRIEF.md
# Two-Master Multiplexed Bus Arbiter and Target Decoder

This block sits at the centre of an on-chip bus that has no tri-state drivers. Two masters share the bus: master 0 is the processor bridge and master 1 is the display refresh engine. Each master raises a request. The arbiter grants one of them with rotating priority and then steers that master's address, write data and read/write strobes to all targets through multiplexers. The granted address is decoded into a one-hot target select. The selected target's read data and acknowledge are multiplexed back, and the acknowledge goes only to the master that owns the bus.

A transfer is a run of one or more words. The master marks the final word with its `last` flag, and it keeps ownership until that word is acknowledged, so a burst is never split. If an address maps to no target, the block answers that word itself after a fixed number of cycles and returns all-ones data.

The controller has two states. In `ST_PARK` nobody holds the bus and no target is selected. In `ST_XFER` one master owns the bus. The transitions are:
- `PARK->XFER`: taken when any master requests.
- `XFER->PARK (done)`: taken when the word flagged `last` is acknowledged.
- `XFER->PARK (drop)`: taken if the owner withdraws its request.

Top module: `dual_bus_arbiter`

## Requirements
- R1: After reset, neither grant is asserted, no target select is asserted and both target strobes are low.
- R2: In the parked state, a request from a single master produces that master's grant at the next clock edge.
- R3: When both masters request in the parked state, the master not granted most recently wins. The reset history counts master 1 as last owner, so master 0 wins the first tie.
- R4: A master keeps its grant, and the other master stays ungranted, until the acknowledge of a word the owner flags as last.
- R5: On the clock edge after the last word's acknowledge, the bus parks for at least one cycle: no grant and no target select. Parking does not alter the priority history.
- R6: The target index is the top SELW address bits. Index k < NT asserts only select bit k while the bus is owned; an index of NT or more asserts no select.
- R7: The targets receive the owner's address, write data, read strobe and write strobe. The strobes are only asserted while a mapped target is selected.
- R8: The selected target's acknowledge is forwarded only to the owning master, in the same cycle. On reads, the shared response data equals that target's read data.
- R9: Each word to an unmapped address is acknowledged in its TMO-th owned cycle (cycle TMO-1, counting from 0), with response data all ones.
- R10: At most one grant is asserted at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m0_req | input | 1 | Processor bridge request |
| m0_last | input | 1 | Processor bridge: current word is final |
| m0_rd | input | 1 | Processor bridge read strobe |
| m0_wr | input | 1 | Processor bridge write strobe |
| m0_addr | input | AW | Processor bridge address |
| m0_wdata | input | DW | Processor bridge write data |
| m0_gnt | output | 1 | Processor bridge grant |
| m0_ack | output | 1 | Processor bridge word acknowledge |
| m1_req | input | 1 | Display engine request |
| m1_last | input | 1 | Display engine: current word is final |
| m1_rd | input | 1 | Display engine read strobe |
| m1_wr | input | 1 | Display engine write strobe |
| m1_addr | input | AW | Display engine address |
| m1_wdata | input | DW | Display engine write data |
| m1_gnt | output | 1 | Display engine grant |
| m1_ack | output | 1 | Display engine word acknowledge |
| rsp_rdata | output | DW | Read data returned to the owner |
| t_sel | output | NT | One-hot target selects |
| t_addr | output | AW | Address to targets |
| t_wdata | output | DW | Write data to targets |
| t_rd | output | 1 | Read strobe to targets |
| t_wr | output | 1 | Write strobe to targets |
| t_rdata | input | NT*DW | Read data of all targets, target k at bits k*DW upward |
| t_ack | input | NT | Acknowledge of each target |

## Verification
Grants are registered, so a grant appears one clock edge after the request is seen while parked. Parking likewise appears one edge after the acknowledge of the last word. Select, strobes, address, data and the forwarded acknowledge follow the target and owner combinationally in the same cycle. An unmapped word is acknowledged TMO-1 cycles after its first owned cycle. The bench changes inputs on the falling edge and samples one time unit later, and it counts falling edges from the grant to place every expectation in its exact cycle.

// File: rtl/mba_pkg.sv
package mba_pkg;
    typedef enum logic [0:0] {
        ST_PARK = 1'b0,
        ST_XFER = 1'b1
    } arb_state_e;

    localparam int N_MASTERS = 2;
endpackage

// File: rtl/mba_fsm.sv
module mba_fsm
    import mba_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req,
    input  logic [N_MASTERS-1:0] last,
    input  logic                 word_ack,
    output arb_state_e           state,
    output logic                 owner,
    output logic [N_MASTERS-1:0] gnt
);
    arb_state_e nstate;
    logic       nowner;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PARK;
            owner <= 1'b1;   // history: master 1 last, so master 0 wins first tie
        end else begin
            state <= nstate;
            owner <= nowner;
        end
    end

    // transitions
    always_comb begin
        nstate = state;
        nowner = owner;
        unique case (state)
            ST_PARK: begin
                if (|req) begin
                    nstate = ST_XFER;
                    nowner = (&req) ? ~owner : req[1];
                end
            end
            ST_XFER: begin
                if (!req[owner] || (word_ack && last[owner]))
                    nstate = ST_PARK;
            end
        endcase
    end

    // outputs
    always_comb begin
        gnt = '0;
        if (state == ST_XFER)
            gnt[owner] = 1'b1;
    end
endmodule

// File: rtl/mba_decode.sv
module mba_decode #(
    parameter int NT   = 5,
    parameter int SELW = 3
) (
    input  logic [SELW-1:0] idx,
    input  logic            en,
    output logic [NT-1:0]   sel,
    output logic            hit
);
    assign hit = (int'(idx) < NT);

    for (genvar k = 0; k < NT; k++) begin : g_sel
        assign sel[k] = en && (idx == SELW'(k));
    end
endmodule

// File: rtl/mba_resp.sv
module mba_resp #(
    parameter int DW  = 32,
    parameter int NT  = 5,
    parameter int TMO = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           active,
    input  logic           hit,
    input  logic [NT-1:0]  sel,
    input  logic [NT*DW-1:0] t_rdata,
    input  logic [NT-1:0]  t_ack,
    output logic           word_ack,
    output logic [DW-1:0]  rdata
);
    localparam int CW = (TMO > 1) ? $clog2(TMO) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(TMO - 1);

    logic [CW-1:0] cnt;
    logic [DW-1:0] picked;
    logic          void_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (active && !hit)
            cnt <= (cnt == CNT_END) ? '0 : cnt + CW'(1);
        else
            cnt <= '0;
    end

    assign void_ack = active && !hit && (cnt == CNT_END);

    always_comb begin
        picked = '0;
        for (int k = 0; k < NT; k++)
            if (sel[k])
                picked = picked | t_rdata[k*DW +: DW];
    end

    assign rdata    = hit ? picked : '1;
    assign word_ack = active && (hit ? |(t_ack & sel) : void_ack);
endmodule

// File: rtl/dual_bus_arbiter.sv
module dual_bus_arbiter
    import mba_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int NT   = 5,
    parameter int SELW = 3,
    parameter int TMO  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m0_req,
    input  logic             m0_last,
    input  logic             m0_rd,
    input  logic             m0_wr,
    input  logic [AW-1:0]    m0_addr,
    input  logic [DW-1:0]    m0_wdata,
    output logic             m0_gnt,
    output logic             m0_ack,
    input  logic             m1_req,
    input  logic             m1_last,
    input  logic             m1_rd,
    input  logic             m1_wr,
    input  logic [AW-1:0]    m1_addr,
    input  logic [DW-1:0]    m1_wdata,
    output logic             m1_gnt,
    output logic             m1_ack,
    output logic [DW-1:0]    rsp_rdata,
    output logic [NT-1:0]    t_sel,
    output logic [AW-1:0]    t_addr,
    output logic [DW-1:0]    t_wdata,
    output logic             t_rd,
    output logic             t_wr,
    input  logic [NT*DW-1:0] t_rdata,
    input  logic [NT-1:0]    t_ack
);
    arb_state_e           state;
    logic                 owner;
    logic [N_MASTERS-1:0] gnt;
    logic                 word_ack;
    logic                 active;
    logic                 hit;
    logic                 own_rd;
    logic                 own_wr;

    mba_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      ({m1_req, m0_req}),
        .last     ({m1_last, m0_last}),
        .word_ack (word_ack),
        .state    (state),
        .owner    (owner),
        .gnt      (gnt)
    );

    assign active = (state == ST_XFER);

    // forward path: owner's control onto the shared target lines
    assign t_addr  = owner ? m1_addr  : m0_addr;
    assign t_wdata = owner ? m1_wdata : m0_wdata;
    assign own_rd  = owner ? m1_rd    : m0_rd;
    assign own_wr  = owner ? m1_wr    : m0_wr;

    mba_decode #(.NT(NT), .SELW(SELW)) u_dec (
        .idx (t_addr[AW-1 -: SELW]),
        .en  (active),
        .sel (t_sel),
        .hit (hit)
    );

    assign t_rd = active && hit && own_rd;
    assign t_wr = active && hit && own_wr;

    // return path
    mba_resp #(.DW(DW), .NT(NT), .TMO(TMO)) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .hit      (hit),
        .sel      (t_sel),
        .t_rdata  (t_rdata),
        .t_ack    (t_ack),
        .word_ack (word_ack),
        .rdata    (rsp_rdata)
    );

    assign m0_gnt = gnt[0];
    assign m1_gnt = gnt[1];
    assign m0_ack = word_ack && gnt[0];
    assign m1_ack = word_ack && gnt[1];
endmodule

// File: rtl/dual_bus_arbiter_chk.sv
module dual_bus_arbiter_chk #(
    parameter int DW = 32,
    parameter int NT = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          m0_req,
    input logic          m0_last,
    input logic          m0_gnt,
    input logic          m0_ack,
    input logic          m1_req,
    input logic          m1_last,
    input logic          m1_gnt,
    input logic          m1_ack,
    input logic [DW-1:0] rsp_rdata,
    input logic [NT-1:0] t_sel,
    input logic          t_rd,
    input logic          t_wr
);
    a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m1_gnt, m0_gnt}));

    a_r6_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(t_sel));

    a_r5_park_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (!m0_gnt && !m1_gnt) |-> (t_sel == '0));

    a_r2_single_m0: assert property (@(posedge clk) disable iff (!rst_n)
        (!m0_gnt && !m1_gnt && m0_req && !m1_req) |=> m0_gnt);

    a_r2_single_m1: assert property (@(posedge clk) disable iff (!rst_n)
        (!m0_gnt && !m1_gnt && m1_req && !m0_req) |=> m1_gnt);

    a_r4_hold_m0: assert property (@(posedge clk) disable iff (!rst_n)
        (m0_gnt && m0_req && !(m0_ack && m0_last)) |=> m0_gnt);

    a_r4_hold_m1: assert property (@(posedge clk) disable iff (!rst_n)
        (m1_gnt && m1_req && !(m1_ack && m1_last)) |=> m1_gnt);

    a_r7_strobe_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (t_rd || t_wr) |-> (t_sel != '0));

    a_r8_ack_m0: assert property (@(posedge clk) disable iff (!rst_n)
        m0_ack |-> m0_gnt);

    a_r8_ack_m1: assert property (@(posedge clk) disable iff (!rst_n)
        m1_ack |-> m1_gnt);

    a_r9_void_ones: assert property (@(posedge clk) disable iff (!rst_n)
        ((m0_ack || m1_ack) && (t_sel == '0)) |-> (&rsp_rdata));
endmodule

bind dual_bus_arbiter dual_bus_arbiter_chk #(.DW(DW), .NT(NT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .m0_req    (m0_req),
    .m0_last   (m0_last),
    .m0_gnt    (m0_gnt),
    .m0_ack    (m0_ack),
    .m1_req    (m1_req),
    .m1_last   (m1_last),
    .m1_gnt    (m1_gnt),
    .m1_ack    (m1_ack),
    .rsp_rdata (rsp_rdata),
    .t_sel     (t_sel),
    .t_rd      (t_rd),
    .t_wr      (t_wr)
);

// File: tb/test_dual_bus_arbiter.sv
module test_dual_bus_arbiter;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NT = 5;
    localparam int SELW = 3;
    localparam int TMO = 8;
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] req = '0, last = '0, rd = '0, wr = '0;
    logic [AW-1:0] addr [2];
    logic [DW-1:0] wdata [2];
    logic [1:0] gnt, ack;
    logic [DW-1:0] rsp_rdata;
    logic [NT-1:0] t_sel;
    logic [AW-1:0] t_addr;
    logic [DW-1:0] t_wdata;
    logic t_rd, t_wr;
    logic [NT*DW-1:0] t_rdata;
    logic [NT-1:0] t_ack;
    logic ack_en = 1'b0;

    int checks = 0;
    int errors = 0;
    int last_owner = 1;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_bus_arbiter #(.AW(AW), .DW(DW), .NT(NT), .SELW(SELW), .TMO(TMO)) i_dual_bus_arbiter (
        .clk(clk), .rst_n(rst_n),
        .m0_req(req[0]), .m0_last(last[0]), .m0_rd(rd[0]), .m0_wr(wr[0]),
        .m0_addr(addr[0]), .m0_wdata(wdata[0]), .m0_gnt(gnt[0]), .m0_ack(ack[0]),
        .m1_req(req[1]), .m1_last(last[1]), .m1_rd(rd[1]), .m1_wr(wr[1]),
        .m1_addr(addr[1]), .m1_wdata(wdata[1]), .m1_gnt(gnt[1]), .m1_ack(ack[1]),
        .rsp_rdata(rsp_rdata), .t_sel(t_sel), .t_addr(t_addr), .t_wdata(t_wdata),
        .t_rd(t_rd), .t_wr(t_wr), .t_rdata(t_rdata), .t_ack(t_ack)
    );

    function automatic logic [DW-1:0] pat(int k, logic [AW-1:0] a);
        return {8'hA0 + 8'(k), 8'h5C, a};
    endfunction

    function automatic logic [NT-1:0] exp_sel(logic [AW-1:0] a);
        int idx = int'(a[AW-1 -: SELW]);
        return (idx < NT) ? (NT'(1) << idx) : '0;
    endfunction

    function automatic int winner(logic [1:0] r, int lo);
        if (r == 2'b11) return 1 - lo;
        return r[1] ? 1 : 0;
    endfunction

    // behavioural targets
    always_comb begin
        t_ack = t_sel & {NT{ack_en}};
        for (int k = 0; k < NT; k++)
            t_rdata[k*DW +: DW] = pat(k, t_addr);
    end

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic setm(int m, logic r, logic [AW-1:0] a, bit w);
        req[m] = r; addr[m] = a; wr[m] = w; rd[m] = !w;
        wdata[m] = $urandom; last[m] = 1'b0;
    endtask

    // caller is at the falling edge after the granting edge
    task automatic serve(int m, logic [AW-1:0] base, bit w, int beats, int lat);
        logic [AW-1:0] a;
        logic [NT-1:0] es;
        #1;
        chk(gnt[m] == 1'b1 && gnt[1-m] == 1'b0, "R2/R3 grant", 64'(gnt), 64'(2'b01 << m));
        chk($onehot0(gnt), "R10 one grant", 64'(gnt), 64'(2'b01 << m));
        last_owner = m;
        for (int b = 0; b < beats; b++) begin
            a = base + AW'(4 * b);
            addr[m] = a; wdata[m] = $urandom; last[m] = (b == beats - 1);
            es = exp_sel(a);
            #1;
            if (es != '0) begin
                for (int c = 0; c < lat; c++) begin
                    ack_en = 1'b0; #1;
                    chk(ack == 2'b00, "R8 no early ack", 64'(ack), 64'd0);
                    chk(t_sel == es, "R6 select", 64'(t_sel), 64'(es));
                    chk(gnt == (2'b01 << m), "R4 hold", 64'(gnt), 64'(2'b01 << m));
                    @(negedge clk);
                end
                ack_en = 1'b1; #1;
                chk(t_sel == es, "R6 select", 64'(t_sel), 64'(es));
                chk(t_addr == a && t_wdata == wdata[m], "R7 addr/data", {t_addr, t_wdata}, {a, wdata[m]});
                chk(t_rd == !w && t_wr == w, "R7 strobes", 64'({t_rd, t_wr}), 64'({!w, w}));
                chk(ack == (2'b01 << m), "R8 ack routing", 64'(ack), 64'(2'b01 << m));
                if (!w) chk(rsp_rdata == pat($clog2(es), a), "R8 rdata", 64'(rsp_rdata), 64'(pat($clog2(es), a)));
                @(negedge clk);
                ack_en = 1'b0;
            end else begin
                for (int c = 0; c < TMO; c++) begin
                    #1;
                    chk(ack == ((c == TMO - 1) ? (2'b01 << m) : 2'b00), "R9 timeout ack", 64'(ack), 64'(c));
                    chk(t_sel == '0 && !t_rd && !t_wr, "R6 no select", 64'({t_sel, t_rd, t_wr}), 64'd0);
                    if (c == TMO - 1) chk(&rsp_rdata, "R9 ones", 64'(rsp_rdata), 64'(32'hFFFFFFFF));
                    @(negedge clk);
                end
            end
        end
        req[m] = 1'b0; last[m] = 1'b0; #1;
        chk(gnt == 2'b00 && t_sel == '0, "R5 park", 64'({gnt, t_sel}), 64'd0);
    endtask

    task automatic contend(logic [1:0] r, logic [AW-1:0] a0, logic [AW-1:0] a1,
                           bit w0, bit w1, int beats, int lat);
        int w;
        w = winner(r, last_owner);
        setm(0, r[0], a0, w0);
        setm(1, r[1], a1, w1);
        @(negedge clk);
        serve(w, w ? a1 : a0, w ? w1 : w0, beats, lat);
        if (r == 2'b11) begin
            @(negedge clk);
            serve(1 - w, w ? a0 : a1, w ? w0 : w1, beats, lat);
        end
    endtask

    initial begin
        void'($urandom(32'd20240607));
        addr[0] = '0; addr[1] = '0; wdata[0] = '0; wdata[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk(gnt == 2'b00 && t_sel == '0 && !t_rd && !t_wr, "R1 reset", 64'({gnt, t_sel, t_rd, t_wr}), 64'd0);
        repeat (2) @(negedge clk);
        #1;
        chk(gnt == 2'b00 && t_sel == '0, "R5 idle parked", 64'({gnt, t_sel}), 64'd0);
        @(negedge clk);
        // R3 first tie goes to master 0; R4 burst of 3 with display waiting
        contend(2'b11, 16'h2010, 16'h8040, 1'b0, 1'b0, 3, 1);
        // R9 unmapped burst
        contend(2'b01, 16'hE000, 16'h0000, 1'b0, 1'b0, 2, 0);
        // R5 idle then tie: last owner 0 so master 1 wins (R3)
        repeat (3) @(negedge clk);
        contend(2'b11, 16'h4100, 16'h6200, 1'b1, 1'b0, 1, 0);
        // R2 same master twice in a row
        contend(2'b10, 16'h0000, 16'h8008, 1'b0, 1'b1, 1, 2);
        contend(2'b10, 16'h0000, 16'hA000, 1'b0, 1'b0, 1, 0);
        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [1:0] r;
            r = 2'($urandom_range(1, 3));
            contend(r, AW'({3'($urandom), 13'($urandom & 32'h0FF0)}),
                       AW'({3'($urandom), 13'($urandom & 32'h0FF0)}),
                    1'($urandom), 1'($urandom), $urandom_range(1, 3), $urandom_range(0, 2));
            if ($urandom_range(0, 1) == 1) @(negedge clk);
        end
        done = 1;
    end

    initial begin
        for (int n = 0; n < 200000 && !done; n++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule